// File: doc/BRIEF.md
# Configurable Serial Byte Shifter

This block moves one byte at a time over a three-wire synchronous link: a serial clock it generates, a data-out line it drives and a data-in line it samples. The host sets a handful of control fields, loads a byte and pulses a start input. The block then runs eight clock cycles on the link, shifting the loaded byte out and a new byte in. At the end it drops its busy flag and raises a one-cycle done pulse, with the received byte ready to read.

The controls cover the following:
- The line order of the bits.
- The level data-out rests at when no transmission is running.
- Separate inversion of the outgoing bits and of the incoming bits.
- A clock divisor.
- A transmit clock polarity and a receive clock polarity.
- A clock enable.

Every control write is guarded, so that it can only take effect while the block is idle. The polarity pair has a stricter guard: it can only be changed while the enable is off, and only to two equal values.

Top module: `serial_byte_shifter`

## Requirements
- R1: After reset, busy, done, rx_byte, sclk and sdo are all 0, and the enable is off.
- R2: When cfg_lsb_first is 0, tx_byte bit 7 goes out first and bit 0 goes out last. When it is 1, bit 0 goes out first. Incoming bits are placed by the same rule, so rx_byte always has normal bit significance.
- R3: While busy is 0, sdo holds the stored idle level, which cfg_idle sets. This includes the time after a transfer ends.
- R4: When busy is 0, sclk rests at the stored transmit polarity. Each half-period of sclk lasts div_val+1 system cycles. Busy stays high for exactly 16*(div_val+1) cycles, counted from the cycle after start is accepted.
- R5: The first sclk edge away from the rest level samples sdi. The edge back to the rest level launches the next bit on sdo. The first bit is on sdo from the start of the transfer. sdo does not change between sclk edges.
- R6: A polarity write (pol_wr) is applied only when the enable is off and pol_tx equals pol_rx. Any other polarity write is ignored.
- R7: When cfg_tx_inv is stored as 1, every bit driven on sdo during a transfer is inverted.
- R8: When cfg_rx_inv is stored as 1, every bit sampled from sdi is inverted before it is stored.
- R9: Writes to bit order, idle level, the inversions and the divisor are ignored while busy is 1.
- R10: start is ignored while busy is 1 or while the enable is off. At the end of a transfer, done is high for one cycle, in the cycle where busy falls, and rx_byte is updated at the same time.
- R11: Writes to the enable are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the order, idle and invert fields |
| cfg_lsb_first | input | 1 | 1 = least significant bit first on the line |
| cfg_idle | input | 1 | Rest level of sdo |
| cfg_tx_inv | input | 1 | Invert outgoing bits |
| cfg_rx_inv | input | 1 | Invert incoming bits |
| div_wr | input | 1 | Write strobe for the divisor |
| div_val | input | DW | Half-period length minus one, in system cycles |
| en_wr | input | 1 | Write strobe for the clock enable |
| en_val | input | 1 | Clock enable value |
| pol_wr | input | 1 | Write strobe for the polarity pair |
| pol_tx | input | 1 | Transmit polarity, which is also the sclk rest level |
| pol_rx | input | 1 | Receive polarity |
| start | input | 1 | Begin a transfer of tx_byte |
| tx_byte | input | W | Byte to send |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |
| rx_byte | output | W | Last received byte |

## Verification
The embedded properties check several things on every cycle:
- done is a single-cycle pulse that coincides with busy falling.
- sclk rests at the transmit polarity whenever the block is idle.
- sdo only moves together with an sclk edge during a transfer.
- The stored fields stay frozen while busy or while the enable is on.

Other behaviour shows only in the bench's sweep, which covers both polarities, both bit orders, both inversions and two divisors against a modelled peripheral. That behaviour includes the exact bit sequence on the wire, the assembled received byte, the transfer length and the rejection of writes and starts that arrive mid-transfer.

// File: rtl/serial_byte_shifter.sv
module serial_byte_shifter #(
  parameter int W  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_lsb_first,
  input  logic          cfg_idle,
  input  logic          cfg_tx_inv,
  input  logic          cfg_rx_inv,
  input  logic          div_wr,
  input  logic [DW-1:0] div_val,
  input  logic          en_wr,
  input  logic          en_val,
  input  logic          pol_wr,
  input  logic          pol_tx,
  input  logic          pol_rx,
  input  logic          start,
  input  logic [W-1:0]  tx_byte,
  input  logic          sdi,
  output logic          sclk,
  output logic          sdo,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rx_byte
);
  localparam int BW = $clog2(W);
  localparam logic [BW:0] LAST_EDGE = (BW+1)'(2*W-1);

  logic          lsb_q, idle_q, tinv_q, rinv_q, ptx_q, prx_q, en_q, phase;
  logic [DW-1:0] div_q, hcnt;
  logic [W-1:0]  tsh, rsh;
  logic [BW:0]   ecnt;

  wire tick   = busy && (hcnt == div_q);
  wire samp   = tick && (sclk == prx_q);
  wire launch = tick && (sclk != ptx_q);
  wire last   = tick && (ecnt == LAST_EDGE);
  wire go     = start && en_q && !busy;
  wire rbit   = sdi ^ rinv_q;

  assign sclk = phase ^ ptx_q;
  assign sdo  = busy ? ((lsb_q ? tsh[0] : tsh[W-1]) ^ tinv_q) : idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q <= 1'b0; idle_q <= 1'b0; tinv_q <= 1'b0; rinv_q <= 1'b0;
      ptx_q <= 1'b0; prx_q <= 1'b0; en_q <= 1'b0; phase <= 1'b0;
      div_q <= '0; hcnt <= '0; tsh <= '0; rsh <= '0; ecnt <= '0;
      busy <= 1'b0; done <= 1'b0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (cfg_wr && !busy) begin
        lsb_q  <= cfg_lsb_first;
        idle_q <= cfg_idle;
        tinv_q <= cfg_tx_inv;
        rinv_q <= cfg_rx_inv;
      end
      if (div_wr && !busy) div_q <= div_val;
      if (en_wr && !busy) en_q <= en_val;
      if (pol_wr && !en_q && (pol_tx == pol_rx)) begin
        ptx_q <= pol_tx;
        prx_q <= pol_rx;
      end
      if (go) begin
        busy  <= 1'b1;
        tsh   <= tx_byte;
        hcnt  <= '0;
        ecnt  <= '0;
        phase <= 1'b0;
      end else if (busy) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick) begin
          phase <= ~phase;
          ecnt  <= ecnt + 1'b1;
        end
        if (samp)
          rsh <= lsb_q ? {rbit, rsh[W-1:1]} : {rsh[W-2:0], rbit};
        if (launch)
          tsh <= lsb_q ? (tsh >> 1) : (tsh << 1);
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= rsh;
          phase   <= 1'b0;
        end
      end
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_with_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_sclk_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == ptx_q));
  assert_sdo_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sclk)) |-> $stable(sdo));
  assert_pol_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> ($stable(ptx_q) && $stable(prx_q)));
  assert_fields_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lsb_q) && $stable(idle_q) && $stable(tinv_q)
                               && $stable(rinv_q) && $stable(div_q)));
  assert_enable_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(en_q));
endmodule

// File: tb/serial_byte_shifter_test.sv
`timescale 1ns/1ps
module serial_byte_shifter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_lsb_first = 0, cfg_idle = 0, cfg_tx_inv = 0, cfg_rx_inv = 0;
  logic div_wr = 0, en_wr = 0, en_val = 0, pol_wr = 0, pol_tx = 0, pol_rx = 0;
  logic start = 0, sdi = 0;
  logic [7:0] div_val = 0, tx_byte = 0;
  logic sclk, sdo, busy, done;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0;
  logic cur_lsb = 0, cur_idle = 0, cur_pol = 0;
  logic [7:0] got;
  int bcnt;

  always #4 clk = ~clk;

  serial_byte_shifter uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_lsb_first(cfg_lsb_first),
    .cfg_idle(cfg_idle), .cfg_tx_inv(cfg_tx_inv), .cfg_rx_inv(cfg_rx_inv),
    .div_wr(div_wr), .div_val(div_val), .en_wr(en_wr), .en_val(en_val),
    .pol_wr(pol_wr), .pol_tx(pol_tx), .pol_rx(pol_rx), .start(start),
    .tx_byte(tx_byte), .sdi(sdi), .sclk(sclk), .sdo(sdo), .busy(busy),
    .done(done), .rx_byte(rx_byte));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk); en_wr = 1; en_val = 0;
    @(negedge clk); en_wr = 0; pol_wr = 1; pol_tx = p; pol_rx = p;
    @(negedge clk); pol_wr = 0; en_wr = 1; en_val = 1;
    @(negedge clk); en_wr = 0;
    cur_pol = p;
  endtask

  task automatic set_cfg(input logic lsb, input logic idl, input logic ti,
                         input logic ri, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_lsb_first = lsb; cfg_idle = idl; cfg_tx_inv = ti; cfg_rx_inv = ri;
    div_wr = 1; div_val = d;
    @(negedge clk); cfg_wr = 0; div_wr = 0;
    cur_lsb = lsb; cur_idle = idl;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input bit meddle);
    int k = 0;
    logic prev;
    sdi = cur_lsb ? slv[0] : slv[7];
    @(negedge clk); start = 1; tx_byte = tx;
    @(negedge clk); start = 0; prev = sclk; bcnt = 0; got = 8'h00;
    while (busy && bcnt < 2000) begin
      bcnt++;
      if (meddle && bcnt == 3) begin
        start = 1; tx_byte = ~tx;
        cfg_wr = 1; cfg_lsb_first = ~cur_lsb; cfg_idle = ~cur_idle; cfg_tx_inv = 1; cfg_rx_inv = 1;
        div_wr = 1; div_val = 8'd7; en_wr = 1; en_val = 0;
      end else begin
        start = 0; cfg_wr = 0; div_wr = 0; en_wr = 0;
      end
      if (sclk != prev) begin
        if (sclk != cur_pol) begin
          if (k < 8) got[cur_lsb ? k : 7 - k] = sdo;
        end else begin
          k++;
          if (k < 8) sdi = cur_lsb ? slv[k] : slv[7 - k];
        end
        prev = sclk;
      end
      @(negedge clk);
    end
    start = 0; cfg_wr = 0; div_wr = 0; en_wr = 0;
    chk("R10 done at busy fall", done, 1);
    @(negedge clk);
    chk("R10 done lasts one cycle", done, 0);
  endtask

  initial begin
    #1600000;
    checks++; fails++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 rx_byte", rx_byte, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 sdo", sdo, 0);
    rst_n = 1;
    @(negedge clk);

    start = 1; tx_byte = 8'h55;
    @(negedge clk); start = 0;
    chk("R10 start ignored while disabled", busy, 0);

    en_wr = 1; en_val = 1;
    @(negedge clk); en_wr = 0; pol_wr = 1; pol_tx = 1; pol_rx = 1;
    @(negedge clk); pol_wr = 0;
    chk("R6 polarity write ignored while enabled", sclk, 0);
    en_wr = 1; en_val = 0;
    @(negedge clk); en_wr = 0; pol_wr = 1; pol_tx = 1; pol_rx = 0;
    @(negedge clk); pol_wr = 0;
    chk("R6 unequal polarity write ignored", sclk, 0);
    pol_wr = 1; pol_tx = 1; pol_rx = 1;
    @(negedge clk); pol_wr = 0;
    chk("R6 equal polarity write applied", sclk, 1);

    for (int p = 0; p < 2; p++) begin
      set_pol(p[0]);
      for (int c = 0; c < 16; c++) begin
        for (int b = 0; b < 2; b++) begin
          logic lsb, ti, ri, idl;
          logic [7:0] d, tx, slv;
          lsb = c[0]; ti = c[1]; ri = c[2];
          d = c[3] ? 8'd2 : 8'd0;
          idl = lsb ^ ti ^ b[0];
          tx  = 8'hA5 ^ 8'((c * 37 + b * 91 + p * 13) & 255);
          slv = 8'h3C + 8'((c * 53 + b * 29 + p * 71) & 255);
          set_cfg(lsb, idl, ti, ri, d);
          chk("R3 idle level before transfer", sdo, idl);
          xfer(tx, slv, 1'b0);
          chk(ti ? "R7 R2 R5 bits on sdo" : "R2 R5 bits on sdo", got, tx ^ {8{ti}});
          chk(ri ? "R8 R2 R5 received byte" : "R2 R5 received byte", rx_byte, slv ^ {8{ri}});
          chk("R4 busy length", bcnt, 16 * (d + 1));
          chk("R4 sclk at rest", sclk, p);
          chk("R3 idle level after transfer", sdo, idl);
        end
      end
    end

    set_pol(1'b0);
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 8'd1);
    xfer(8'hC3, 8'h96, 1'b1);
    chk("R10 start while busy ignored", got, 8'hC3);
    chk("R9 invert write while busy ignored", rx_byte, 8'h96);
    chk("R9 divisor write while busy ignored", bcnt, 32);
    chk("R9 idle write while busy ignored", sdo, 1);
    xfer(8'h1E, 8'h2D, 1'b0);
    chk("R11 enable write while busy ignored", bcnt, 32);
    chk("R9 order write while busy ignored", got, 8'h1E);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule